// File: doc/BRIEF.md
# Accumulator Processor Core

A small single-accumulator processor that runs programs of 16-bit words held in an external 256-word memory. Each instruction carries an 8-bit operation code in its upper byte and an 8-bit direct memory address in its lower byte. The core fetches one word, decodes it and executes it. It then moves on to the next address, or jumps when the branch condition holds. This repeats until a halt instruction freezes it.

The memory is synchronous, with one cycle of read latency. It has a separate read-data bus and write-data bus, and both share one registered address. Inside the core are a program counter, a memory address register, a memory buffer register, an opcode register, an operand buffer and the accumulator. A multi-cycle sequencer drives all transfers between them. Every output is taken straight from a register.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, and on the clock edge that follows, mem_addr is 0, mem_we is 0 and halted is 0. The first instruction after reset is fetched from address 0.
- R2: Opcode 02h loads the word at address X into the accumulator. Opcode 01h writes the accumulator to address X. Its write strobe is raised with the address already settled.
- R3: Opcode 03h adds the word at X to the accumulator, and opcode 04h subtracts it. Both wrap modulo 2^16.
- R4: Opcode 06h combines the accumulator bitwise AND with the word at X, and opcode 07h combines it bitwise OR. Opcode 08h inverts the accumulator and ignores its address field.
- R5: Opcode 09h shifts the accumulator right by one bit, and opcode 0Ah shifts it left by one bit. Both shifts are logical and fill with zero.
- R6: Opcode 0Bh multiplies the accumulator by the word at X and keeps the low 16 bits of the product.
- R7: Opcode 05h loads the address field into the program counter when accumulator bit 15 is 0. When bit 15 is 1, execution continues at the next address.
- R8: Opcode 0Ch raises halted. Halted then stays high until reset. After halt the core makes no further memory writes and mem_addr does not change.
- R9: Opcodes 00h and 0Dh to FFh advance the program counter only. They change neither the accumulator nor memory.
- R10: A program that sums 100 down to 0 leaves 5050 (13BAh) in its sum cell and FFFFh in its counter cell. The program occupies 00h to 0Bh, with its constants and variables at A0h to A4h.
- R11: mem_we is never high on two consecutive cycles. Each store instruction produces exactly one write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Read data from the memory, one cycle after the address |
| mem_addr | output | 8 | Registered memory address |
| mem_wdata | output | 16 | Registered write data |
| mem_we | output | 1 | Registered write strobe |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Each instruction group runs in a short program of its own, and the results come back out through store instructions to memory. The arithmetic programs use operands that force carries and borrows across the whole word, such as FFFFh+2 and 0-1, so a missing wrap is caught. The multiply programs use operands whose product overflows 16 bits, so a core that keeps the wrong half of the product gives a different result. The shift operand has both end bits set, which separates logical fill from rotation. The branch program runs one jump with a positive accumulator and one with a negative accumulator, each followed by a trap store. The unassigned-opcode program carries an address field that points at a cell which must stay untouched. The full summation loop ties all of this together, and it also checks the exit condition on the counter's final value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_STORE = 8'h01;
  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h02;
  localparam logic [OPC_W-1:0] OP_ADD   = 8'h03;
  localparam logic [OPC_W-1:0] OP_SUB   = 8'h04;
  localparam logic [OPC_W-1:0] OP_JPOS  = 8'h05;
  localparam logic [OPC_W-1:0] OP_AND   = 8'h06;
  localparam logic [OPC_W-1:0] OP_OR    = 8'h07;
  localparam logic [OPC_W-1:0] OP_INV   = 8'h08;
  localparam logic [OPC_W-1:0] OP_SHR   = 8'h09;
  localparam logic [OPC_W-1:0] OP_SHL   = 8'h0A;
  localparam logic [OPC_W-1:0] OP_MUL   = 8'h0B;
  localparam logic [OPC_W-1:0] OP_HALT  = 8'h0C;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_INV, ALU_SHR, ALU_SHL, ALU_MUL
  } alu_op_e;

  typedef enum logic [3:0] {
    S_FETCH_A, S_FETCH_B, S_FETCH_C, S_DECODE,
    S_STORE_A, S_STORE_B,
    S_READ_A, S_READ_B, S_READ_C,
    S_EXEC, S_HALT
  } seq_state_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_mbr;
    logic mbr_mem;
    logic mbr_acc;
    logic pc_inc;
    logic pc_load;
    logic ir_load;
    logic br_load;
    logic acc_clr;
    logic acc_alu;
    logic we_set;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] prod;

  assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_INV: y = ~a;
      ALU_SHR: y = {1'b0, a[DW-1:1]};
      ALU_SHL: y = {a[DW-2:0], 1'b0};
      ALU_MUL: y = prod[DW-1:0];
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] mbr_op,
  input  logic [OPC_W-1:0] ir_op,
  input  logic             acc_sign,
  output ctl_t             ctl,
  output alu_op_e          alu_op,
  output logic             halted
);

  seq_state_e state_q, state_d;
  logic       halted_q;

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    unique case (state_q)
      S_FETCH_A: begin
        ctl.mar_pc = 1'b1;
        state_d    = S_FETCH_B;
      end
      S_FETCH_B: state_d = S_FETCH_C;
      S_FETCH_C: begin
        ctl.mbr_mem = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_d     = S_DECODE;
      end
      S_DECODE: begin
        ctl.ir_load = 1'b1;
        ctl.mar_mbr = 1'b1;
        unique case (mbr_op)
          OP_STORE: state_d = S_STORE_A;
          OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_MUL: state_d = S_READ_A;
          OP_INV, OP_SHR, OP_SHL: state_d = S_EXEC;
          OP_JPOS: begin
            ctl.pc_load = ~acc_sign;
            state_d     = S_FETCH_A;
          end
          OP_HALT: state_d = S_HALT;
          default: state_d = S_FETCH_A;
        endcase
      end
      S_STORE_A: begin
        ctl.mbr_acc = 1'b1;
        ctl.we_set  = 1'b1;
        state_d     = S_STORE_B;
      end
      S_STORE_B: state_d = S_FETCH_A;
      S_READ_A:  state_d = S_READ_B;
      S_READ_B: begin
        ctl.mbr_mem = 1'b1;
        state_d     = S_READ_C;
      end
      S_READ_C: begin
        ctl.br_load = 1'b1;
        ctl.acc_clr = (ir_op == OP_LOAD);
        state_d     = S_EXEC;
      end
      S_EXEC: begin
        ctl.acc_alu = 1'b1;
        state_d     = S_FETCH_A;
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_FETCH_A;
    endcase
  end

  always_comb begin
    unique case (ir_op)
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      OP_OR:   alu_op = ALU_OR;
      OP_INV:  alu_op = ALU_INV;
      OP_SHR:  alu_op = ALU_SHR;
      OP_SHL:  alu_op = ALU_SHL;
      OP_MUL:  alu_op = ALU_MUL;
      default: alu_op = ALU_ADD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_FETCH_A;
      halted_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      halted_q <= (state_d == S_HALT);
    end
  end

  assign halted = halted_q;

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [DW-1:0]    alu_y,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    mar,
  output logic [DW-1:0]    mbr,
  output logic [OPC_W-1:0] ir,
  output logic [DW-1:0]    br,
  output logic [DW-1:0]    acc,
  output logic             we_q
);

  logic [AW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      mbr  <= '0;
      ir   <= '0;
      br   <= '0;
      acc  <= '0;
      we_q <= 1'b0;
    end else begin
      if (ctl.pc_load)     pc <= mbr[AW-1:0];
      else if (ctl.pc_inc) pc <= pc + AW'(1);

      if (ctl.mar_pc)       mar <= pc;
      else if (ctl.mar_mbr) mar <= mbr[AW-1:0];

      if (ctl.mbr_mem)      mbr <= mem_rdata;
      else if (ctl.mbr_acc) mbr <= acc;

      if (ctl.ir_load) ir <= mbr[AW +: OPC_W];
      if (ctl.br_load) br <= mbr;

      if (ctl.acc_clr)      acc <= '0;
      else if (ctl.acc_alu) acc <= alu_y;

      we_q <= ctl.we_set;
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          halted
);

  ctl_t             ctl;
  alu_op_e          alu_op;
  logic [DW-1:0]    mbr, br, acc, alu_y;
  logic [OPC_W-1:0] ir;
  logic [AW-1:0]    mar;
  logic             we_q;

  acc_cpu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .mbr_op   (mbr[AW +: OPC_W]),
    .ir_op    (ir),
    .acc_sign (acc[DW-1]),
    .ctl      (ctl),
    .alu_op   (alu_op),
    .halted   (halted)
  );

  acc_cpu_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .alu_y     (alu_y),
    .mem_rdata (mem_rdata),
    .mar       (mar),
    .mbr       (mbr),
    .ir        (ir),
    .br        (br),
    .acc       (acc),
    .we_q      (we_q)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op (alu_op),
    .a  (acc),
    .b  (br),
    .y  (alu_y)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = we_q;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !mem_we && !halted));

  assert_write_addr_settled_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $stable(mem_addr));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  assert_halt_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));

  assert_single_write_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted)
);

// File: tb/acc_cpu_core_bench.sv
`timescale 1ns/1ps
module acc_cpu_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic        halted;

  logic        ram_clr = 1'b0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] mem [256];
  int          we_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  acc_cpu_core u_acc_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  always @(posedge clk) begin
    if (ram_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
    if (!rst && mem_we) we_cnt <= we_cnt + 1;
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    ram_clr = 1'b1;
    @(negedge clk);
    ram_clr = 1'b0;
  endtask

  task automatic poke(logic [7:0] a, logic [15:0] d);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_prog(string tag);
    int cyc;
    cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " halt reached"}, {15'b0, halted}, 16'h0001);
  endtask

  task automatic t_reset();
    begin_prog();
    repeat (2) @(negedge clk);
    check("R1 addr in reset", {8'h0, mem_addr}, 16'h0000);
    check("R1 we/halted in reset", {14'b0, mem_we, halted}, 16'h0000);
    poke(8'h00, 16'h0C00);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first fetch addr", {8'h0, mem_addr}, 16'h0000);
    repeat (4) @(negedge clk);
    check("R1 halt at addr 0 fetched", {15'b0, halted}, 16'h0001);
  endtask

  task automatic t_load_store();
    int w0;
    begin_prog();
    poke(8'h10, 16'h1234);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0120); poke(8'h02, 16'h0C00);
    w0 = we_cnt;
    run_prog("R2");
    check("R2 load/store", mem[8'h20], 16'h1234);
    check("R11 one write per store", 16'(we_cnt - w0), 16'h0001);
  endtask

  task automatic t_arith();
    begin_prog();
    poke(8'h10, 16'hFFFF); poke(8'h11, 16'h0002); poke(8'h12, 16'h0000); poke(8'h13, 16'h0001);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0311); poke(8'h02, 16'h0120);
    poke(8'h03, 16'h0211); poke(8'h04, 16'h0410); poke(8'h05, 16'h0121);
    poke(8'h06, 16'h0212); poke(8'h07, 16'h0413); poke(8'h08, 16'h0122);
    poke(8'h09, 16'h0C00);
    run_prog("R3");
    check("R3 add wrap", mem[8'h20], 16'h0001);
    check("R3 sub 2-FFFF", mem[8'h21], 16'h0003);
    check("R3 sub 0-1", mem[8'h22], 16'hFFFF);
  endtask

  task automatic t_logic();
    begin_prog();
    poke(8'h10, 16'hF0F0); poke(8'h11, 16'h3C3C);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0611); poke(8'h02, 16'h0120);
    poke(8'h03, 16'h0210); poke(8'h04, 16'h0711); poke(8'h05, 16'h0121);
    poke(8'h06, 16'h0210); poke(8'h07, 16'h0811); poke(8'h08, 16'h0122);
    poke(8'h09, 16'h0C00);
    run_prog("R4");
    check("R4 and", mem[8'h20], 16'h3030);
    check("R4 or", mem[8'h21], 16'hFCFC);
    check("R4 not", mem[8'h22], 16'h0F0F);
    check("R4 not leaves X alone", mem[8'h11], 16'h3C3C);
  endtask

  task automatic t_shift();
    begin_prog();
    poke(8'h10, 16'h8001);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0900); poke(8'h02, 16'h0120);
    poke(8'h03, 16'h0210); poke(8'h04, 16'h0A00); poke(8'h05, 16'h0121);
    poke(8'h06, 16'h0C00);
    run_prog("R5");
    check("R5 shift right", mem[8'h20], 16'h4000);
    check("R5 shift left", mem[8'h21], 16'h0002);
  endtask

  task automatic t_mul();
    begin_prog();
    poke(8'h10, 16'h0123); poke(8'h11, 16'h0456); poke(8'h12, 16'hFFFF);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0B11); poke(8'h02, 16'h0120);
    poke(8'h03, 16'h0212); poke(8'h04, 16'h0B12); poke(8'h05, 16'h0121);
    poke(8'h06, 16'h0C00);
    run_prog("R6");
    check("R6 mul low half", mem[8'h20], 16'hEDC2);
    check("R6 mul FFFF*FFFF", mem[8'h21], 16'h0001);
  endtask

  task automatic t_jump();
    begin_prog();
    poke(8'h10, 16'h0005); poke(8'h11, 16'h8000);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0504); poke(8'h02, 16'h0120);
    poke(8'h03, 16'h0C00); poke(8'h04, 16'h0211); poke(8'h05, 16'h0508);
    poke(8'h06, 16'h0121); poke(8'h07, 16'h0C00); poke(8'h08, 16'h0122);
    poke(8'h09, 16'h0C00);
    run_prog("R7");
    check("R7 taken skips store", mem[8'h20], 16'h0000);
    check("R7 not taken falls through", mem[8'h21], 16'h8000);
    check("R7 not taken no jump", mem[8'h22], 16'h0000);
  endtask

  task automatic t_noop();
    begin_prog();
    poke(8'h10, 16'h00AA);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0D55); poke(8'h02, 16'h0055);
    poke(8'h03, 16'hFF55); poke(8'h04, 16'h0120); poke(8'h05, 16'h0C00);
    run_prog("R9");
    check("R9 acc kept across no-ops", mem[8'h20], 16'h00AA);
    check("R9 no-op writes nothing", mem[8'h55], 16'h0000);
  endtask

  task automatic t_halt();
    int w0;
    logic [7:0] a0;
    bit ok;
    begin_prog();
    poke(8'h10, 16'h0777);
    poke(8'h00, 16'h0210); poke(8'h01, 16'h0C00); poke(8'h02, 16'h0120);
    run_prog("R8");
    w0 = we_cnt;
    a0 = mem_addr;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!halted || mem_addr != a0) ok = 1'b0;
    end
    check("R8 frozen after halt", {15'b0, ok}, 16'h0001);
    check("R8 no writes after halt", 16'(we_cnt - w0), 16'h0000);
    check("R8 word after halt unexecuted", mem[8'h20], 16'h0000);
  endtask

  task automatic t_sum();
    begin_prog();
    poke(8'h00, 16'h02A0); poke(8'h01, 16'h01A4); poke(8'h02, 16'h02A2);
    poke(8'h03, 16'h01A3); poke(8'h04, 16'h02A4); poke(8'h05, 16'h03A3);
    poke(8'h06, 16'h01A4); poke(8'h07, 16'h02A3); poke(8'h08, 16'h04A1);
    poke(8'h09, 16'h01A3); poke(8'h0A, 16'h0504); poke(8'h0B, 16'h0C00);
    poke(8'hA1, 16'h0001); poke(8'hA2, 16'h0064);
    run_prog("R10");
    check("R10 sum 1..100", mem[8'hA4], 16'h13BA);
    check("R10 counter exit value", mem[8'hA3], 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load_store();
    t_arith();
    t_logic();
    t_shift();
    t_mul();
    t_jump();
    t_noop();
    t_halt();
    t_sum();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule